// File: doc/BRIEF.md
# Free-Running Compare-Toggle Timer

This block is a 16-bit up-counter that runs without stopping. It advances on a count-enable strobe taken from a small prescaler, so it counts once every 1, 2, 4 or 8 system clocks. Software loads a 16-bit compare value ahead of time. Each time the counter reaches that value, the block raises a one-clock interrupt pulse. If both toggling and the output are enabled, the timer output pin also changes level. A match never clears the counter, so the same compare value matches again after a full 65536-count lap.

A sticky overflow flag records that the counter has rolled over from FFFFH to 0000H. It stays set until software writes 0 to it. The flag sits in an 8-bit mode register next to the clock select, the toggle enable, the output enable and a read-only copy of the output level. A simple write/read register port reaches the mode register and the compare register, and it also reads the live counter. Capture edge bits are kept in the mode register so that software can read them back. No capture logic is built.

Top module: `cmp_toggle_timer`

## Requirements
- R1: After reset the counter, compare register and mode register read 0, and `tmr_out` and `irq` are low. The counter adds exactly one on each count enable and wraps from FFFFH to 0000H.
- R2: Mode bits [2:1] select the count rate. Codes 0, 1, 2 and 3 advance the counter once every 1, 2, 4 and 8 clocks respectively.
- R3: When the counter becomes equal to the compare value, the output level inverts if mode bit 3 (toggle enable) and mode bit 0 (output enable) are both 1. The counter takes the compare value in the same cycle that the new level appears.
- R4: Every compare match produces an `irq` pulse exactly one clock wide, in the cycle in which the counter shows the compare value. This holds whatever the toggle and output enables are set to.
- R5: A match does not clear or stop the counter. It holds compare+1 in the next cycle, and the next match comes exactly 65536 count enables later.
- R6: Mode bit 6 (overflow) is set on the FFFFH to 0000H wrap and stays set. A write to the mode register with bit 6 = 0 clears it, and a write with bit 6 = 1 leaves it unchanged.
- R7: While mode bit 0 is 0, `tmr_out` is low and match toggling is suppressed. When output is enabled again, the output starts from low.
- R8: Mode bit 7 reads back the current output level, and writes to bit 7 are ignored.
- R9: Address map: 0 is the mode register (bits [7:0]; upper read bits are 0, and bits 5:4 are stored and read back). Address 1 is the compare register. Address 2 reads the counter, and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | One-clock compare-match interrupt pulse |

## Verification
The bench measures the counter advance over 16-clock windows for every clock-select code. A divider tapped at the wrong bit would give the wrong count difference. It runs one complete lap past the compare value. This exposes a design that clears the counter on a match, since the second match would come early, and a design that misses the FFFFH to 0000H overflow set. It also checks the flag's write-0-to-clear and write-1-no-effect behaviour. Separate scenarios turn off toggling and the output. A design that toggled regardless, dropped `irq` when toggling was off, or resumed from a stale high level after re-enable would be caught there. Writes to the read-only output-level bit and to the counter address are checked for having no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned CNT_W  = 16;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  // Stored, software-written part of the mode register
  typedef struct packed {
    logic [1:0]       edge_sel;
    logic             tog_en;
    logic [SEL_W-1:0] rate_sel;
    logic             out_en;
  } cfg_t;

  // Full 8-bit view of the mode register, MSB first
  typedef struct packed {
    logic             level;
    logic             wrap_flag;
    logic [1:0]       edge_sel;
    logic             tog_en;
    logic [SEL_W-1:0] rate_sel;
    logic             out_en;
  } mode_view_t;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick
);

  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] tap_mask;

  // Mask of the low divider bits that must all be 1 for a strobe
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      tap_mask[i] = (32'(rate_sel) > i);
    end
  end

  always_comb begin
    div_d = div_q + 1'b1;
    tick  = ((div_q & tap_mask) == tap_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         roll
);

  logic [W-1:0] cnt_q, cnt_d, cnt_inc;

  always_comb begin
    cnt_inc = W'(cnt_q + 1'b1);
    cnt_d   = tick ? cnt_inc : cnt_q;
    // events describe the value the counter is about to take
    hit     = tick && (cnt_inc == cmp);
    roll    = tick && (cnt_q == {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic tog_en,
  input  logic hit,
  output logic level
);

  logic lvl_q, lvl_d;

  always_comb begin
    if (!out_en)            lvl_d = 1'b0;
    else if (hit && tog_en) lvl_d = ~lvl_q;
    else                    lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;

endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tmr_out,
  output logic              irq
);

  localparam int unsigned MODE_W = $bits(mode_view_t);

  logic             rst_q_n;
  logic             tick;
  logic             hit;
  logic             roll;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  cfg_t             cfg_q, cfg_d;
  logic             wrap_q, wrap_d;
  logic             irq_q, irq_d;
  mode_view_t       mode_rd;
  logic             wr_mode, wr_cmp;

  tmr_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  tmr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .rate_sel (cfg_q.rate_sel),
    .tick     (tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tick  (tick),
    .cmp   (cmp_q),
    .cnt   (cnt_q),
    .hit   (hit),
    .roll  (roll)
  );

  tmr_outctl u_out (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .out_en (cfg_q.out_en),
    .tog_en (cfg_q.tog_en),
    .hit    (hit),
    .level  (lvl_q)
  );

  // Next-state for the register file
  always_comb begin
    wr_mode = wr_en && (wr_addr == ADDR_MODE);
    wr_cmp  = wr_en && (wr_addr == ADDR_CMP);

    cfg_d  = cfg_q;
    cmp_d  = cmp_q;
    wrap_d = wrap_q;
    irq_d  = hit;

    if (wr_mode) begin
      cfg_d = cfg_t'(wr_data[MODE_W-3:0]);
      if (!wr_data[MODE_W-2]) wrap_d = 1'b0;
    end
    if (wr_cmp) cmp_d = wr_data[CNT_W-1:0];
    if (roll)   wrap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= '0;
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (!rst_q_n) begin
      cfg_q  <= '0;
      cmp_q  <= '0;
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cmp_q  <= cmp_d;
      wrap_q <= wrap_d;
      irq_q  <= irq_d;
    end
  end

  // Read side
  always_comb begin
    mode_rd.level     = lvl_q;
    mode_rd.wrap_flag = wrap_q;
    mode_rd.edge_sel  = cfg_q.edge_sel;
    mode_rd.tog_en    = cfg_q.tog_en;
    mode_rd.rate_sel  = cfg_q.rate_sel;
    mode_rd.out_en    = cfg_q.out_en;
    case (rd_addr)
      ADDR_MODE: rd_data = DATA_W'(mode_rd);
      ADDR_CMP:  rd_data = DATA_W'(cmp_q);
      ADDR_CNT:  rd_data = DATA_W'(cnt_q);
      default:   rd_data = '0;
    endcase
  end

  assign tmr_out = lvl_q & cfg_q.out_en;
  assign irq     = irq_q;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cnt,
  input logic [15:0] cmp,
  input logic        irq,
  input logic        lvl,
  input logic        oen,
  input logic        ovf
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == 16'($past(cnt) + 16'd1))); // R1

  AST_LVL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> (irq || !$past(oen))); // R3

  AST_IRQ_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == $past(cmp))); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cnt) == 16'hFFFF) && (cnt == 16'h0000)) |-> ovf); // R6

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oen |=> !lvl); // R7

endmodule

bind cmp_toggle_timer tmr_chk u_chk (
  .clk (clk),
  .rst_n (rst_q_n),
  .cnt (cnt_q),
  .cmp (cmp_q),
  .irq (irq),
  .lvl (lvl_q),
  .oen (cfg_q.out_en),
  .ovf (wrap_q)
);

// File: tb/cmp_toggle_timer_tb.sv
`timescale 1ns/100ps
module cmp_toggle_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        tmr_out;
  logic        irq;

  int total = 0;
  int bad   = 0;

  cmp_toggle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_out(tmr_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    logic [15:0] v, c0;
    rst_n = 1'b0; wr_en = 1'b0; rd_addr = '0;
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R1 reset mode", v, 16'h0000);
    rd(2'd1, v); check("R1 reset cmp", v, 16'h0000);
    rd(2'd2, v); check("R1 reset cnt", v, 16'h0000);
    check("R1 reset out", tmr_out, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd2, c0);
    @(negedge clk);
    rd(2'd2, v); check("R1 step by one", v, 16'(c0 + 16'd1));
  endtask

  task automatic t_rates();
    logic [15:0] c0, c1;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 16'(s << 1));
      @(negedge clk);
      rd(2'd2, c0);
      repeat (16) @(negedge clk);
      rd(2'd2, c1);
      check($sformatf("R2 rate code %0d", s), 16'(c1 - c0), 16'(16 >> s));
    end
  endtask

  task automatic t_toggle();
    logic [15:0] v;
    bit seen;
    do_reset();
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h0009);
    check("R7 enabled starts low", tmr_out, 1'b0);
    wait_irq(seen);
    check("R4 irq seen", seen, 1'b1);
    rd(2'd2, v); check("R3 cnt at match", v, 16'h0040);
    check("R3 output toggled", tmr_out, 1'b1);
    rd(2'd0, v); check("R8 level readback", v[7], 1'b1);
    @(negedge clk);
    check("R4 irq one clock", irq, 1'b0);
    rd(2'd2, v); check("R5 counting continues", v, 16'h0041);
    wr(2'd0, 16'h0009);
    rd(2'd0, v); check("R8 bit7 write ignored", v[7], 1'b1);
    check("R8 out kept", tmr_out, 1'b1);
  endtask

  task automatic t_no_toggle();
    bit seen;
    do_reset();
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h0001);
    wait_irq(seen);
    check("R4 irq with toggle off", seen, 1'b1);
    check("R3 no toggle when disabled", tmr_out, 1'b0);
  endtask

  task automatic t_out_off();
    logic [15:0] v;
    bit seen;
    do_reset();
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h0008);
    wait_irq(seen);
    check("R4 irq with output off", seen, 1'b1);
    check("R7 out low while off", tmr_out, 1'b0);
    @(negedge clk);
    rd(2'd0, v); check("R7 level held low", v[7], 1'b0);
    wr(2'd0, 16'h0009);
    check("R7 re-enable starts low", tmr_out, 1'b0);
    wr(2'd1, 16'h0080);
    wait_irq(seen);
    check("R3 toggle after enable", tmr_out, 1'b1);
  endtask

  task automatic t_lap();
    logic [15:0] v, prev, m;
    int irqs;
    bit seen;
    do_reset();
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'h0009);
    wait_irq(seen);
    rd(2'd2, prev);
    check("R5 first match", prev, 16'h0020);
    irqs = 0;
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      if (irq) irqs++;
      rd(2'd2, v);
      if (prev == 16'hFFFF) begin
        check("R1 wrap to zero", v, 16'h0000);
        rd(2'd0, m); check("R6 flag set on wrap", m[6], 1'b1);
      end else if (v == 16'hFFFF) begin
        rd(2'd0, m); check("R6 flag clear before wrap", m[6], 1'b0);
      end
      prev = v;
    end
    check("R5 no early match", irqs, 0);
    @(negedge clk);
    check("R5 match after full lap", irq, 1'b1);
    rd(2'd2, v); check("R5 cnt at second match", v, 16'h0020);
    check("R3 second toggle", tmr_out, 1'b0);
    wr(2'd0, 16'h0049);
    rd(2'd0, m); check("R6 write one keeps set", m[6], 1'b1);
    wr(2'd0, 16'h0009);
    rd(2'd0, m); check("R6 write zero clears", m[6], 1'b0);
    wr(2'd0, 16'h0049);
    rd(2'd0, m); check("R6 write one does not set", m[6], 1'b0);
  endtask

  task automatic t_map();
    logic [15:0] v, c0;
    do_reset();
    wr(2'd0, 16'hFF36);
    rd(2'd0, v); check("R9 mode readback", v, 16'h0036);
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); check("R9 cmp readback", v, 16'hBEEF);
    rd(2'd3, v); check("R9 addr3 zero", v, 16'h0000);
    wr(2'd0, 16'h0000);
    @(negedge clk);
    rd(2'd2, c0);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check("R9 cnt write ignored", v, 16'(c0 + 16'd2));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rates();
    t_toggle();
    t_no_toggle();
    t_out_off();
    t_map();
    t_lap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule